// File: doc/BRIEF.md
# Clock-Failure Detect and Switchover Controller

This block watches a slow main clock from the domain of an always-running internal oscillator and reacts when the main clock stops. The main clock is treated as a data input. It is synchronized, and each of its transitions clears a silence counter. When the counter runs long enough without a transition, the main clock is declared stopped. When transitions return, it is declared restarted.

Software controls the block through one 8-bit register. A mode bit selects how the block reacts to a stop. In reset mode it emits a one-cycle system-reset request. In interrupt mode it sets a sticky event flag and pulses an interrupt. It also moves the CPU clock selection to the internal oscillator, but only when the CPU is not running from the PLL. A write-enable input guards every register write, and a lock input additionally freezes the detection-enable bit.

Top module: `cfd_ctrl`

## Requirements
- R1: After reset the register reads 0x02 (bit1 clock select = 1, all other bits 0), clk_sel is 1, and irq and rst_req are 0.
- R2: A register write takes effect only when wr_unlock is 1. With wr_unlock at 0 the register keeps its value.
- R3: While clk_lock is 1, a write leaves bit0 (detection enable) unchanged, and the other written bits still take effect.
- R4: Bit3 (main-clock stopped) reads 1 once the synchronized main clock has shown no transition for STOP_LIMIT consecutive cycles. It returns to 0 on the next transition. Writes never change it.
- R5: With bit0 = 1 and bit7 (action) = 1, both a stop and a restart of the main clock set bit2 (event flag). Every 0-to-1 change of bit2 produces a one-cycle pulse on irq.
- R6: Bit2 is cleared only by a write with bit2 = 0. A write with bit2 = 1 leaves it unchanged.
- R7: With bit0 = 1, bit7 = 1 and pll_sel = 0, a detected stop sets bit1 (and clk_sel) to 1 without software.
- R8: With pll_sel = 1, a detected stop leaves bit1 unchanged while still setting bit2 and pulsing irq.
- R9: With bit0 = 1 and bit7 = 0, a detected stop gives a single-cycle rst_req pulse. Bits 0, 1, 2 and 7 keep their values, and no irq is raised.
- R10: A write with bit1 = 0 is ignored for bit1 while bit0 = 1 and bit3 = 1.
- R11: With bit0 = 0, stops and restarts change neither bit1 nor bit2 and raise neither irq nor rst_req. Bit3 still follows the main clock.
- R12: Bits 6:4 always read 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal-oscillator clock, clocks all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| wr_unlock | input | 1 | 1 allows register writes |
| clk_lock | input | 1 | 1 freezes the detection-enable bit |
| main_clk | input | 1 | Monitored main clock, sampled as data |
| pll_sel | input | 1 | 1 when the CPU clock comes from the PLL |
| rst_req | output | 1 | One-cycle system-reset request |
| irq | output | 1 | One-cycle interrupt request |
| clk_sel | output | 1 | CPU clock select, 1 = internal oscillator |

## Verification
The main clock is run steadily, held still long enough to cross the stop threshold, and then restarted. This is repeated under each combination of enable, action mode and PLL selection. The runs separate the interrupt-mode switchover from the PLL case, where the selection must stay put, and from reset mode, where only a reset pulse may appear. The disabled case, with no reaction at all, is run as well. A restart after the flag has been cleared shows that restarts set the flag too. A restart with the flag still set shows that no second interrupt appears. Protected, locked and reserved-bit writes are issued between these runs to show which bits each write reaches.

// File: rtl/cfd_pkg.sv
// Package: shared bit positions and types for the clock-failure controller.
// Assumes an 8-bit control/status register with fixed field positions.
package cfd_pkg;
    localparam int REG_W   = 8;
    localparam int B_EN    = 0;
    localparam int B_SEL   = 1;
    localparam int B_FLAG  = 2;
    localparam int B_MON   = 3;
    localparam int B_ACT   = 7;
    localparam logic [REG_W-1:0] RESET_VALUE = 8'h02;

    // Detector events handed to the register block.
    typedef struct packed {
        logic stopped;   // main clock currently considered stopped
        logic stop_evt;  // stop declared this cycle
        logic rest_evt;  // restart declared this cycle
    } det_t;
endpackage

// File: rtl/cfd_sync.sv
// Module: cfd_sync
// Brings the main clock into the oscillator domain through a flop chain and
// flags any transition of the synchronized level. Assumes STAGES >= 2.
module cfd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic toggled
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Purpose: first stage captures the asynchronous level.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_in;
    end

    // Purpose: remaining stages settle metastability.
    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    // Purpose: remember previous synchronized level for transition detect.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign toggled = chain_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/cfd_stop_det.sv
// Module: cfd_stop_det
// Counts oscillator cycles since the last main-clock transition. Declares a
// stop when the count reaches LIMIT and a restart at the next transition.
// Assumes LIMIT >= 2.
module cfd_stop_det
    import cfd_pkg::*;
#(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic toggled,
    output det_t det
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);

    logic [CW-1:0] quiet_q;
    logic          stopped_q;
    logic          hit;

    assign hit = !toggled && (quiet_q == LAST);

    // Purpose: silence counter, cleared by transitions, saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n)          quiet_q <= '0;
        else if (toggled)    quiet_q <= '0;
        else if (quiet_q != TOP) quiet_q <= quiet_q + 1'b1;
    end

    // Purpose: stopped status, set at the threshold, cleared by a transition.
    always_ff @(posedge clk) begin
        if (!rst_n)       stopped_q <= 1'b0;
        else if (toggled) stopped_q <= 1'b0;
        else if (hit)     stopped_q <= 1'b1;
    end

    assign det.stopped  = stopped_q;
    assign det.stop_evt = hit;
    assign det.rest_evt = toggled && stopped_q;
endmodule

// File: rtl/cfd_csr.sv
// Module: cfd_csr
// Control/status register with hardware reactions to detector events:
// event flag, interrupt pulse, reset-request pulse and automatic switch to
// the internal oscillator. Hardware updates win over a write in the same cycle.
module cfd_csr
    import cfd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             unlock,
    input  logic             lock_en,
    input  logic             pll_sel,
    input  det_t             det,
    output logic [REG_W-1:0] rdata,
    output logic             irq,
    output logic             rst_req
);
    logic en_q, sel_q, flag_q, act_q, irq_q, rreq_q;
    logic wr_ok, stop_hit, rest_hit, flag_set, auto_sel, sel_wr_ok;

    assign wr_ok     = wr && unlock;
    assign stop_hit  = en_q && det.stop_evt;
    assign rest_hit  = en_q && det.rest_evt;
    assign flag_set  = act_q && (stop_hit || rest_hit);
    assign auto_sel  = act_q && stop_hit && !pll_sel;
    assign sel_wr_ok = wdata[B_SEL] || !(en_q && det.stopped);

    // Purpose: enable and action bits, written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= RESET_VALUE[B_EN];
            act_q <= RESET_VALUE[B_ACT];
        end else if (wr_ok) begin
            act_q <= wdata[B_ACT];
            if (!lock_en) en_q <= wdata[B_EN];
        end
    end

    // Purpose: clock select, written by software, forced high on a stop.
    always_ff @(posedge clk) begin
        if (!rst_n)                   sel_q <= RESET_VALUE[B_SEL];
        else if (auto_sel)            sel_q <= 1'b1;
        else if (wr_ok && sel_wr_ok)  sel_q <= wdata[B_SEL];
    end

    // Purpose: sticky event flag, cleared only by writing zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                       flag_q <= RESET_VALUE[B_FLAG];
        else if (flag_set)                flag_q <= 1'b1;
        else if (wr_ok && !wdata[B_FLAG]) flag_q <= 1'b0;
    end

    // Purpose: one-cycle interrupt on a flag rise, reset request in reset mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            rreq_q <= 1'b0;
        end else begin
            irq_q  <= flag_set && !flag_q;
            rreq_q <= stop_hit && !act_q;
        end
    end

    // Purpose: assemble read data; unassigned and reserved bits read zero.
    always_comb begin
        rdata         = '0;
        rdata[B_EN]   = en_q;
        rdata[B_SEL]  = sel_q;
        rdata[B_FLAG] = flag_q;
        rdata[B_MON]  = det.stopped;
        rdata[B_ACT]  = act_q;
    end

    assign irq     = irq_q;
    assign rst_req = rreq_q;
endmodule

// File: rtl/cfd_ctrl.sv
// Module: cfd_ctrl (top)
// Clock-failure detect and switchover controller. All logic runs on the
// internal-oscillator clock; the main clock is sampled as data.
module cfd_ctrl
    import cfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STOP_LIMIT  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             wr_unlock,
    input  logic             clk_lock,
    input  logic             main_clk,
    input  logic             pll_sel,
    output logic             rst_req,
    output logic             irq,
    output logic             clk_sel
);
    logic toggled;
    det_t det;

    cfd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (main_clk),
        .toggled  (toggled)
    );

    cfd_stop_det #(.LIMIT(STOP_LIMIT)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .toggled (toggled),
        .det     (det)
    );

    cfd_csr u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .unlock  (wr_unlock),
        .lock_en (clk_lock),
        .pll_sel (pll_sel),
        .det     (det),
        .rdata   (reg_rdata),
        .irq     (irq),
        .rst_req (rst_req)
    );

    assign clk_sel = reg_rdata[B_SEL];
endmodule

// File: rtl/cfd_ctrl_chk.sv
// Module: cfd_ctrl_chk
// Protocol checks on the controller's ports, bound to every cfd_ctrl.
module cfd_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       wr_unlock,
    input logic       clk_lock,
    input logic       pll_sel,
    input logic       rst_req,
    input logic       irq,
    input logic       clk_sel
);
    p_irq_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (reg_rdata[2] && !$past(reg_rdata[2])));

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[2] && !(reg_wr && wr_unlock && !reg_wdata[2])) |=> reg_rdata[2]);

    p_guarded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && wr_unlock) |=> ($stable(reg_rdata[0]) && $stable(reg_rdata[7])));

    p_en_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_lock |=> $stable(reg_rdata[0]));

    p_pll_keeps_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_sel && !clk_sel && !(reg_wr && wr_unlock)) |=> !clk_sel);

    p_rst_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_rst_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(reg_rdata[0] && !reg_rdata[7]));

    p_quiet_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[0] |=> (!irq && !rst_req));

    p_zero_bits_r12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6:4] == 3'b000);
endmodule

bind cfd_ctrl cfd_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .wr_unlock (wr_unlock),
    .clk_lock  (clk_lock),
    .pll_sel   (pll_sel),
    .rst_req   (rst_req),
    .irq       (irq),
    .clk_sel   (clk_sel)
);

// File: tb/cfd_ctrl_bench.sv
// Bench: behavioural cycle model compared every clock, plus scenario checks.
module cfd_ctrl_bench;
    localparam int LIM = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       wr_unlock = 1'b0;
    logic       clk_lock = 1'b0;
    logic       main_clk = 1'b0;
    logic       pll_sel = 1'b0;
    logic       rst_req, irq, clk_sel;

    int total = 0;
    int bad = 0;
    bit mrun = 1'b0;
    bit cmp_on = 1'b0;
    int irq_seen = 0;
    int rst_seen = 0;

    always #2 clk = ~clk;

    cfd_ctrl #(.SYNC_STAGES(2), .STOP_LIMIT(LIM)) u_cfd_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wr_unlock(wr_unlock), .clk_lock(clk_lock),
        .main_clk(main_clk), .pll_sel(pll_sel), .rst_req(rst_req),
        .irq(irq), .clk_sel(clk_sel)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model state (behavioural).
    bit q[$];
    int m_quiet;
    bit m_stop, m_en, m_sel, m_flag, m_act, m_irq, m_rst;

    always @(posedge clk) begin
        if (!rst_n) begin
            q = '{1'b0, 1'b0, 1'b0};
            m_quiet = 0; m_stop = 0; m_en = 0; m_sel = 1; m_flag = 0;
            m_act = 0; m_irq = 0; m_rst = 0;
        end else begin
            bit tog, s_ev, r_ev, old_stop, wok, fset;
            tog = q[1] ^ q[0];
            void'(q.pop_front());
            q.push_back(main_clk);
            s_ev = !tog && (m_quiet == LIM - 1);
            r_ev = tog && m_stop;
            old_stop = m_stop;
            if (tog) begin m_quiet = 0; m_stop = 0; end
            else if (m_quiet < LIM) begin
                m_quiet++;
                if (m_quiet == LIM) m_stop = 1;
            end
            s_ev = s_ev && m_en;
            r_ev = r_ev && m_en;
            wok = reg_wr && wr_unlock;
            fset = m_act && (s_ev || r_ev);
            m_irq = fset && !m_flag;
            m_rst = s_ev && !m_act;
            if (m_act && s_ev && !pll_sel) m_sel = 1;
            else if (wok && (reg_wdata[1] || !(m_en && old_stop))) m_sel = reg_wdata[1];
            if (fset) m_flag = 1;
            else if (wok && !reg_wdata[2]) m_flag = 0;
            if (wok) begin
                m_act = reg_wdata[7];
                if (!clk_lock) m_en = reg_wdata[0];
            end
        end
    end

    // Every-cycle comparison against the model, and pulse counting.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2 rdata", reg_rdata,
                {m_act, 3'b000, m_stop, m_flag, m_sel, m_en});
            chk("R7 clk_sel", {7'd0, clk_sel}, {7'd0, m_sel});
            chk("R5 irq", {7'd0, irq}, {7'd0, m_irq});
            chk("R9 rst_req", {7'd0, rst_req}, {7'd0, m_rst});
            if (irq) irq_seen++;
            if (rst_req) rst_seen++;
        end
    end

    // Main clock source: toggles every two cycles while running.
    initial begin
        forever begin
            @(negedge clk);
            if (mrun) begin
                @(negedge clk);
                if (mrun) main_clk = ~main_clk;
            end
        end
    end

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        int irq0, rst0;
        mrun = 1'b1;
        idle(4);
        @(negedge clk); rst_n = 1'b1; cmp_on = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 reset rdata", reg_rdata, 8'h02);
        chk("R1 reset outs", {5'd0, clk_sel, irq, rst_req}, 8'h04);
        // R2 protected write ignored
        wr(8'h81);
        idle(1);
        chk("R2 protected", reg_rdata, 8'h02);
        // R3 enable frozen by lock
        wr_unlock = 1'b1; clk_lock = 1'b1;
        wr(8'h81);
        idle(1);
        chk("R3 lock", reg_rdata, 8'h80);
        // R12 reserved bits read zero
        clk_lock = 1'b0;
        wr(8'hF1);
        idle(1);
        chk("R12 zero bits", reg_rdata, 8'h81);
        // R4 R5 R7 stop in interrupt mode, main clock feeding CPU
        irq0 = irq_seen;
        mrun = 1'b0;
        idle(LIM + 8);
        chk("R7 auto switch", reg_rdata, 8'h8F);
        chk("R5 stop irq", 8'(irq_seen - irq0), 8'd1);
        // R10 select cannot be cleared while stopped; R6 write 1 keeps flag
        wr(8'h85);
        idle(1);
        chk("R10 sel held", reg_rdata, 8'h8F);
        // R4 restart clears monitor; flag already set, no second irq
        mrun = 1'b1;
        idle(8);
        chk("R4 restart mon", reg_rdata, 8'h87);
        chk("R5 no second irq", 8'(irq_seen - irq0), 8'd1);
        // R6 clear by writing 0
        wr(8'h81);
        idle(1);
        chk("R6 clear", reg_rdata, 8'h81);
        // R5 restart also sets flag
        mrun = 1'b0;
        idle(LIM + 8);
        wr(8'h83);
        idle(1);
        chk("R6 clear while stopped", reg_rdata, 8'h8B);
        irq0 = irq_seen;
        mrun = 1'b1;
        idle(8);
        chk("R5 restart flag", reg_rdata, 8'h87);
        chk("R5 restart irq", 8'(irq_seen - irq0), 8'd1);
        // R8 PLL feeding CPU: select stays
        wr(8'h81);
        pll_sel = 1'b1;
        irq0 = irq_seen;
        mrun = 1'b0;
        idle(LIM + 8);
        chk("R8 pll sel kept", reg_rdata, 8'h8D);
        chk("R8 pll irq", 8'(irq_seen - irq0), 8'd1);
        mrun = 1'b1;
        idle(8);
        pll_sel = 1'b0;
        // R9 reset mode
        wr(8'h01);
        irq0 = irq_seen; rst0 = rst_seen;
        mrun = 1'b0;
        idle(LIM + 8);
        chk("R9 bits kept", reg_rdata, 8'h09);
        chk("R9 one pulse", 8'(rst_seen - rst0), 8'd1);
        chk("R9 no irq", 8'(irq_seen - irq0), 8'd0);
        mrun = 1'b1;
        idle(8);
        chk("R9 restart quiet", reg_rdata, 8'h01);
        // R11 detection disabled
        wr(8'h80);
        irq0 = irq_seen; rst0 = rst_seen;
        mrun = 1'b0;
        idle(LIM + 8);
        chk("R11 disabled", reg_rdata, 8'h88);
        mrun = 1'b1;
        idle(8);
        chk("R11 restart", reg_rdata, 8'h80);
        chk("R11 no pulses", 8'((irq_seen - irq0) + (rst_seen - rst0)), 8'd0);
        finish_run();
    end
endmodule